// File: doc/BRIEF.md
# Five-Line Prioritised Interrupt Arbiter

This block sits next to a small 8-bit processor core and turns five hardware request lines into one pending request. Each line has its own trigger rule.

- The non-maskable line needs a rising edge and must also still be high.
- The edge line latches a rising edge.
- The two level lines count only while they are held high.
- The external line is a plain level.

The block ranks the requests in a fixed order. It applies a three-bit mask and a global enable. It then tells the core whether a request is pending and which 16-bit restart address to jump to. When the external line wins, no address is given. Instead a flag tells the core that the requesting device must supply the address.

The core takes a request with a one-cycle accept strobe. Accepting clears the global enable. If the accepted source was an edge-capturing source, its capture latch is cleared as well. Accepting the external line also produces a one-cycle acknowledge pulse on the following cycle, so that the device can drive its address. The mask is loaded through a write strobe. The same write can also discard a held edge on the edge line.

Top module: `irq_arbiter`

## Requirements
- R1: Priority is fixed, from highest to lowest: nmi_i, edge_i, lvl_hi_i, lvl_lo_i, ext_i. Only the highest pending source drives the outputs.
- R2: Restart addresses are 0x0024 for nmi_i, 0x003C for edge_i, 0x0034 for lvl_hi_i and 0x002C for lvl_lo_i. vec_o is 0 when nothing is pending or when ext_i wins.
- R3: A rising edge on nmi_i sets a latch. A rising edge means high at a clock edge after being low at the previous one. The line is pending from the next cycle, for as long as nmi_i stays high and the latch is set. The mask and the global enable have no effect on it.
- R4: A rising edge on edge_i is latched on the same kind of clock edge, even while the line is masked. The edge stays held after the input falls, until the line is accepted or cleared by a mask write. It is pending when the latch is set, the line is unmasked and the global enable is set.
- R5: lvl_hi_i and lvl_lo_i are pending in the same cycle they are high, provided they are unmasked and enabled. They stop being pending as soon as they go low.
- R6: A cycle with mask_we_i high loads mask_data_i, effective from the next cycle. Bit 2 masks edge_i, bit 1 masks lvl_hi_i and bit 0 masks lvl_lo_i, and 1 means blocked. If edge_clr_i is also high in that cycle, the edge_i latch is cleared. A rising edge captured in that same cycle still sets the latch.
- R7: en_set_i sets the global enable and en_clr_i clears it, both from the next cycle. While the enable is low, only nmi_i can raise irq_o.
- R8: take_i with irq_o high clears the global enable, and this wins over en_set_i. If the winner was nmi_i or edge_i, it also clears that source's latch. take_i with irq_o low changes nothing.
- R9: When ext_i wins, irq_o and ext_vec_o are high and vec_o is 0. Accepting it raises ext_ack_o for exactly the next cycle.
- R10: Reset clears both latches and the global enable, sets all three mask bits, and leaves irq_o, ext_vec_o and ext_ack_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request, edge and level sensitive |
| edge_i | input | 1 | Maskable request, rising-edge captured |
| lvl_hi_i | input | 1 | Maskable level request, upper rank |
| lvl_lo_i | input | 1 | Maskable level request, lower rank |
| ext_i | input | 1 | Level request whose address comes from the device |
| mask_we_i | input | 1 | Mask write strobe |
| mask_data_i | input | 3 | Mask bits {edge, lvl_hi, lvl_lo}; 1 blocks the line |
| edge_clr_i | input | 1 | With mask_we_i: discard the held edge_i edge |
| en_set_i | input | 1 | Set the global enable |
| en_clr_i | input | 1 | Clear the global enable |
| take_i | input | 1 | Core accepts the current request |
| irq_o | output | 1 | A request is pending |
| vec_o | output | VEC_W | Restart address of the winning source |
| ext_vec_o | output | 1 | The winner is ext_i; the device must supply the address |
| ext_ack_o | output | 1 | One-cycle acknowledge after ext_i is accepted |

## Verification
The bench builds the block with its defaults: VEC_W = 16 and VEC_UNIT = 4. These give the exact 16-bit restart addresses, so every vector is compared bit for bit against the expected constants. Directed steps take the block out of reset and through these cases:

- mask writes, with and without the edge clear;
- enable set, clear and collision with an accept;
- accepts against each winner, and an accept with nothing pending;
- a non-maskable request while disabled.

A long randomised run then mixes simultaneous requests, short pulses and accepts. Its purpose is to reach edges that coincide with clears and accepts.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Source indices, in ascending rank order (0 wins)
    localparam int NSRC     = 5;
    localparam int IDX_NMI  = 0;
    localparam int IDX_EDGE = 1;
    localparam int IDX_HI   = 2;
    localparam int IDX_LO   = 3;
    localparam int IDX_EXT  = 4;

    // Mask bit positions
    localparam int MB_EDGE = 2;
    localparam int MB_HI   = 1;
    localparam int MB_LO   = 0;
    localparam int MASK_W  = 3;

    typedef struct packed {
        logic              prev;
        logic              seen;
    } catch_s;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              en;
        logic              ack;
    } ctl_s;

endpackage

// File: rtl/irq_edge_catch.sv
module irq_edge_catch
    import irq_arb_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    input  logic clr_i,
    output logic seen_o
);

    catch_s cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.prev = line_i;
        // a fresh edge in the same cycle as a clear survives
        nxt_d.seen = (cur_q.seen & ~clr_i) | (line_i & ~cur_q.prev);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign seen_o = cur_q.seen;

    // R4: a captured edge persists while no clear arrives
    a_r4_edge_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_o && !clr_i) |=> seen_o);

    // R3: a low-to-high step on the line is remembered by the next cycle
    a_r3_edge_caught: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_i && !cur_q.prev) |=> seen_o);

endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_arb_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mask_we_i,
    input  logic [MASK_W-1:0] mask_data_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              take_ok_i,
    input  logic              ext_won_i,
    output logic [MASK_W-1:0] mask_o,
    output logic              en_o,
    output logic              ack_o
);

    ctl_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (mask_we_i) nxt_d.mask = mask_data_i;
        if (take_ok_i)     nxt_d.en = 1'b0;
        else if (en_set_i) nxt_d.en = 1'b1;
        else if (en_clr_i) nxt_d.en = 1'b0;
        nxt_d.ack = take_ok_i & ext_won_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.mask <= '1;
            cur_q.en   <= 1'b0;
            cur_q.ack  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mask_o = cur_q.mask;
    assign en_o   = cur_q.en;
    assign ack_o  = cur_q.ack;

    // R8: acceptance always leaves the enable off
    a_r8_take_clears_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_ok_i |=> !en_o);

    // R6: a mask write lands on the next cycle
    a_r6_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_we_i |=> (mask_o == $past(mask_data_i)));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_arb_pkg::*;
#(
    parameter int VEC_W    = 16,
    parameter int VEC_UNIT = 4
)(
    input  logic [NSRC-1:0]  pend_i,
    output logic [NSRC-1:0]  grant_o,
    output logic             any_o,
    output logic             ext_o,
    output logic [VEC_W-1:0] vec_o
);

    localparam int NVEC = NSRC - 1;
    // restart address = half-step number * VEC_UNIT
    localparam logic [VEC_W-1:0] VTAB [NVEC] = '{
        VEC_W'(9  * VEC_UNIT),
        VEC_W'(15 * VEC_UNIT),
        VEC_W'(13 * VEC_UNIT),
        VEC_W'(11 * VEC_UNIT)
    };

    logic [NSRC-1:0] above;

    // above[k]: some higher-ranked source is pending
    assign above[0] = 1'b0;
    for (genvar k = 1; k < NSRC; k++) begin : g_rank
        assign above[k] = above[k-1] | pend_i[k-1];
    end

    assign grant_o = pend_i & ~above;
    assign any_o   = |pend_i;
    assign ext_o   = grant_o[IDX_EXT];

    always_comb begin
        vec_o = '0;
        for (int k = 0; k < NVEC; k++) begin
            if (grant_o[k]) vec_o = VTAB[k];
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int VEC_W    = 16,
    parameter int VEC_UNIT = 4
)(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              nmi_i,
    input  logic              edge_i,
    input  logic              lvl_hi_i,
    input  logic              lvl_lo_i,
    input  logic              ext_i,
    input  logic              mask_we_i,
    input  logic [MASK_W-1:0] mask_data_i,
    input  logic              edge_clr_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              take_i,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              ext_vec_o,
    output logic              ext_ack_o
);

    localparam int NCATCH = 2;
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(9 * VEC_UNIT);

    logic [NCATCH-1:0] catch_line, catch_clr, catch_seen;
    logic [NSRC-1:0]   pend, grant;
    logic [MASK_W-1:0] mask_q;
    logic              en_q, take_ok, any;

    assign take_ok = take_i & any;

    // edge-capturing sources: index 0 = non-maskable, 1 = edge line
    assign catch_line = {edge_i, nmi_i};
    assign catch_clr[IDX_NMI]  = take_ok & grant[IDX_NMI];
    assign catch_clr[IDX_EDGE] = (take_ok & grant[IDX_EDGE]) | (mask_we_i & edge_clr_i);

    for (genvar c = 0; c < NCATCH; c++) begin : g_catch
        irq_edge_catch u_catch (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .line_i (catch_line[c]),
            .clr_i  (catch_clr[c]),
            .seen_o (catch_seen[c])
        );
    end

    irq_ctl_regs u_ctl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mask_we_i   (mask_we_i),
        .mask_data_i (mask_data_i),
        .en_set_i    (en_set_i),
        .en_clr_i    (en_clr_i),
        .take_ok_i   (take_ok),
        .ext_won_i   (grant[IDX_EXT]),
        .mask_o      (mask_q),
        .en_o        (en_q),
        .ack_o       (ext_ack_o)
    );

    assign pend[IDX_NMI]  = catch_seen[IDX_NMI] & nmi_i;
    assign pend[IDX_EDGE] = catch_seen[IDX_EDGE] & ~mask_q[MB_EDGE] & en_q;
    assign pend[IDX_HI]   = lvl_hi_i & ~mask_q[MB_HI] & en_q;
    assign pend[IDX_LO]   = lvl_lo_i & ~mask_q[MB_LO] & en_q;
    assign pend[IDX_EXT]  = ext_i & en_q;

    irq_prio_enc #(.VEC_W(VEC_W), .VEC_UNIT(VEC_UNIT)) u_enc (
        .pend_i  (pend),
        .grant_o (grant),
        .any_o   (any),
        .ext_o   (ext_vec_o),
        .vec_o   (vec_o)
    );

    assign irq_o = any;

    // R3: a latched non-maskable request that is still high always wins
    a_r3_nmi_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (catch_seen[IDX_NMI] && nmi_i) |-> (irq_o && vec_o == NMI_VEC));

    // R7: with the enable off only the non-maskable line can request
    a_r7_disabled_nmi_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_q && irq_o) |-> (vec_o == NMI_VEC));

    // R5: a level source only wins while its line is high
    a_r5_hi_needs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant[IDX_HI] |-> lvl_hi_i);
    a_r5_lo_needs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant[IDX_LO] |-> lvl_lo_i);

    // R9: device-supplied address carries no vector; ack follows acceptance
    a_r9_ext_no_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_vec_o |-> (irq_o && vec_o == '0));
    a_r9_ack_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_ack_o |-> $past(take_i && ext_vec_o));

    // R1: at most one source drives the outputs
    a_r1_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant));

endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi = 0, edg = 0, hi = 0, lo = 0, ext = 0;
    logic        mwe = 0, eclr = 0, eset = 0, ecl = 0, take = 0;
    logic [2:0]  mdat = '0;
    logic        irq, extv, ack;
    logic [15:0] vec;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // behavioural reference state
    int m_nprev, m_nlat, m_eprev, m_elat, m_en, m_ack;
    int m_mask [3];   // index 2 edge, 1 hi, 0 lo

    always #5 clk = ~clk;

    irq_arbiter dut (
        .clk_i(clk), .rst_ni(rst_n),
        .nmi_i(nmi), .edge_i(edg), .lvl_hi_i(hi), .lvl_lo_i(lo), .ext_i(ext),
        .mask_we_i(mwe), .mask_data_i(mdat), .edge_clr_i(eclr),
        .en_set_i(eset), .en_clr_i(ecl), .take_i(take),
        .irq_o(irq), .vec_o(vec), .ext_vec_o(extv), .ext_ack_o(ack)
    );

    task automatic model_reset();
        m_nprev = 0; m_nlat = 0; m_eprev = 0; m_elat = 0; m_en = 0; m_ack = 0;
        foreach (m_mask[i]) m_mask[i] = 1;
    endtask

    // winner: 0 none, 1 nmi, 2 edge, 3 hi, 4 lo, 5 ext
    function automatic int winner();
        if (m_nlat && nmi) return 1;
        if (m_en == 0) return 0;
        if (m_elat && !m_mask[2]) return 2;
        if (hi && !m_mask[1]) return 3;
        if (lo && !m_mask[0]) return 4;
        if (ext) return 5;
        return 0;
    endfunction

    function automatic logic [15:0] addr_of(int w);
        case (w)
            1: return 16'h0024;
            2: return 16'h003C;
            3: return 16'h0034;
            4: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic compare(string tag);
        int w;
        logic e_irq, e_ext, e_ack;
        logic [15:0] e_vec;
        w = winner();
        e_irq = (w != 0);
        e_ext = (w == 5);
        e_vec = addr_of(w);
        e_ack = (m_ack != 0);
        vectors++;
        if (irq !== e_irq || vec !== e_vec || extv !== e_ext || ack !== e_ack) begin
            miscompares++;
            $display("FAIL %s t=%0t irq/vec/ext/ack got %0b/%h/%0b/%0b expected %0b/%h/%0b/%0b",
                     tag, $time, irq, vec, extv, ack, e_irq, e_vec, e_ext, e_ack);
        end
    endtask

    task automatic model_step();
        int w, tk, nl, el;
        w  = winner();
        tk = take && (w != 0);
        nl = (m_nlat && !(tk && w == 1)) || (nmi && !m_nprev);
        el = (m_elat && !((tk && w == 2) || (mwe && eclr))) || (edg && !m_eprev);
        m_nlat = nl; m_nprev = nmi;
        m_elat = el; m_eprev = edg;
        if (mwe) begin
            m_mask[2] = mdat[2]; m_mask[1] = mdat[1]; m_mask[0] = mdat[0];
        end
        if (tk) m_en = 0;
        else if (eset) m_en = 1;
        else if (ecl) m_en = 0;
        m_ack = tk && (w == 5);
    endtask

    // one clock: drive at the falling edge, compare before the rising edge
    task automatic cyc(string tag, logic [4:0] lines, logic w_e, logic [2:0] w_d,
                       logic w_c, logic s, logic c, logic t);
        @(negedge clk);
        {ext, lo, hi, edg, nmi} = lines;
        mwe = w_e; mdat = w_d; eclr = w_c; eset = s; ecl = c; take = t;
        #3;
        compare(tag);
        model_step();
        @(posedge clk);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: idle after reset; requests with enable off and mask set do nothing
        cyc("R10", 5'b00000, 0, 3'b000, 0, 0, 0, 0);
        cyc("R10", 5'b11110, 0, 3'b000, 0, 0, 0, 0);   // edge_i latched while masked
        cyc("R10", 5'b11100, 0, 3'b000, 0, 0, 0, 0);
        // R7: enabling with all masked lets only ext through
        cyc("R7", 5'b10000, 0, 3'b000, 0, 1, 0, 0);
        cyc("R7", 5'b10000, 0, 3'b000, 0, 0, 0, 0);
        // R9: accept ext, ack next cycle, enable drops
        cyc("R9", 5'b10000, 0, 3'b000, 0, 0, 0, 1);
        cyc("R9", 5'b10000, 0, 3'b000, 0, 0, 0, 0);
        // R8: accept with nothing pending is ignored
        cyc("R8", 5'b00000, 0, 3'b000, 0, 0, 0, 1);
        // R6: unmask everything, keep the held edge, enable
        cyc("R6", 5'b00000, 1, 3'b000, 0, 1, 0, 0);
        // R4: held edge wins over levels (R2 address 0x003C)
        cyc("R4", 5'b01100, 0, 3'b000, 0, 0, 0, 0);
        // R6: clear the held edge by a mask write, then levels show
        cyc("R6", 5'b01100, 1, 3'b000, 1, 0, 0, 0);
        cyc("R5", 5'b01100, 0, 3'b000, 0, 0, 0, 0);
        cyc("R5", 5'b01000, 0, 3'b000, 0, 0, 0, 0);
        cyc("R5", 5'b00000, 0, 3'b000, 0, 0, 0, 0);
        // R6: mask only lvl_hi_i
        cyc("R6", 5'b01100, 1, 3'b010, 0, 0, 0, 0);
        cyc("R6", 5'b01100, 0, 3'b010, 0, 0, 0, 0);
        // R4: new edge, pulse drops, held; accept clears it
        cyc("R4", 5'b00010, 0, 3'b000, 0, 0, 0, 0);
        cyc("R4", 5'b00000, 0, 3'b000, 0, 0, 0, 0);
        cyc("R8", 5'b00000, 0, 3'b000, 0, 1, 0, 1);   // take beats enable set
        cyc("R8", 5'b00000, 0, 3'b000, 0, 1, 0, 0);
        cyc("R8", 5'b00000, 0, 3'b000, 0, 0, 0, 0);
        // R3: non-maskable request while disabled and fully masked
        cyc("R3", 5'b00000, 1, 3'b111, 0, 0, 1, 0);
        cyc("R3", 5'b00001, 0, 3'b000, 0, 0, 0, 0);
        cyc("R3", 5'b00001, 0, 3'b000, 0, 0, 0, 0);
        cyc("R3", 5'b00000, 0, 3'b000, 0, 0, 0, 0);
        cyc("R3", 5'b00001, 0, 3'b000, 0, 0, 0, 1);
        cyc("R3", 5'b00001, 0, 3'b000, 0, 0, 0, 1);
        cyc("R3", 5'b00001, 0, 3'b000, 0, 0, 0, 0);
        // R1: everything at once, peel off in rank order
        cyc("R1", 5'b00000, 1, 3'b000, 0, 1, 0, 0);
        cyc("R1", 5'b11111, 0, 3'b000, 0, 0, 0, 0);
        cyc("R1", 5'b11111, 0, 3'b000, 0, 0, 0, 0);
        cyc("R1", 5'b11110, 0, 3'b000, 0, 0, 0, 0);
        cyc("R1", 5'b11100, 0, 3'b000, 0, 1, 0, 1);
        cyc("R1", 5'b11100, 0, 3'b000, 0, 1, 0, 0);
        cyc("R1", 5'b11000, 0, 3'b000, 0, 0, 0, 0);
        cyc("R2", 5'b10000, 0, 3'b000, 0, 0, 0, 0);

        // R1 R2: randomised mix compared every clock
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] l;
            l[0] = ($urandom_range(0, 7) == 0) ? ~nmi : nmi;
            l[1] = ($urandom_range(0, 3) == 0) ? ~edg : edg;
            l[2] = ($urandom_range(0, 3) == 0) ? ~hi  : hi;
            l[3] = ($urandom_range(0, 3) == 0) ? ~lo  : lo;
            l[4] = ($urandom_range(0, 3) == 0) ? ~ext : ext;
            cyc("R1", l,
                ($urandom_range(0, 9) == 0), 3'($urandom_range(0, 7)),
                ($urandom_range(0, 1) == 0),
                ($urandom_range(0, 2) == 0), ($urandom_range(0, 9) == 0),
                ($urandom_range(0, 3) == 0));
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog expired after %0d vectors, expected completion", vectors);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule